// File: doc/BRIEF.md
# Microcontroller Program Download Port

This block fills the byte-wide program store of an embedded microcontroller through one 32-bit control word on a host bus. Each word written carries three things. The top byte is an operating code. The next byte is a program byte. The low half-word is a location. When the code selects upload, the core is held in reset and the byte is stored at the location given. The stored location also becomes the current position of an internal pointer.

A host read in upload mode returns the upload code, the byte at the pointer and the pointer itself, and then moves the pointer on by one. The host can therefore check the whole image by reading the one register over and over. Before it checks, it reads until the returned location is zero. When the image is in place, the host writes a "loaded" code with the image size, then a "run" code with the size. The run code releases the core. From then on the core fetches from the same store through its own port.

Top module: `prog_load_port`

## Requirements
- R1: After reset the read word is 0x00000000, the core reset output is high and the fetch data is 0x00.
- R2: A write whose code byte (bits 31:24) is 0x0F stores bits 23:16 at the location in bits 13:0, sets the pointer to that location and keeps the core in reset.
- R3: While the stored code is 0x0F, a read returns {0x0F, stored byte, 2'b00, 14-bit pointer}. It then advances the pointer by one.
- R4: Bits 15:14 of a written location are ignored, and read back as zero. The pointer wraps from the last location of the store to 0.
- R5: A write whose code is not 0x0F never changes the store. It records bits 15:0 as the size. Reads then return {code, 0x00, size} and leave the pointer where it was.
- R6: A write whose code has a low nibble of 0xF drives the core reset high. Otherwise, a write whose code has bit 4 (word bit 28) set drives it low. Any other write, such as code 0x03, leaves it unchanged.
- R7: When a write and a read arrive in the same cycle, the write is applied and the read has no effect. The read word is unchanged.
- R8: While the core runs, the fetch data is the stored byte at the fetch address. While the core is held in reset, the fetch data is 0x00.
- R9: An upload write whose location lies beyond the store depth (a nonzero bit at 13:ADDR_W) stores nothing and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the control word |
| host_rd | input | 1 | Host read strobe for the control word |
| host_wdata | input | 32 | Control word written by the host |
| host_rdata | output | 32 | Control word captured by the last accepted read |
| mcu_rst | output | 1 | Reset to the microcontroller core, high = held |
| mcu_addr | input | ADDR_W | Core fetch address |
| mcu_data | output | 8 | Core fetch byte |

## Verification
The assertions assume the strobes are single-cycle and known whenever reset is released. They also assume that the upload code is only ever stored while the core reset is high, which follows from R6. The bench drives every strobe for exactly one cycle. It reads back only locations it has written first, so no check ever compares a byte the store never received. The bench uses the fetch port only after a run code has released the core, except for one check that the fetch data is 0x00 while the core is held.

// File: rtl/pld_pkg.sv
package pld_pkg;

    localparam logic [7:0] CODE_UPLOAD = 8'h0F;
    localparam int         LOC_W       = 14;
    localparam int         BYTE_W      = 8;

    typedef struct packed {
        logic [7:0]  code;
        logic [7:0]  data;
        logic [15:0] loc;
    } ctl_word_t;

endpackage

// File: rtl/pld_mem.sv
module pld_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[addr] <= wdata;
    end

    assign rdata = store_q[addr];
endmodule

// File: rtl/pld_ctrl.sv
module pld_ctrl
    import pld_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] host_addr,
    output logic [7:0]        mem_wdata,
    output logic [31:0]       rdata,
    output logic              core_rst
);
    typedef struct packed {
        logic [7:0]        code;
        logic [ADDR_W-1:0] ptr;
        logic [15:0]       size;
        logic [31:0]       rword;
        logic              hold;
    } ctl_state_t;

    ctl_state_t s_d, s_q;
    ctl_word_t  w;
    logic       upload_wr;
    logic       in_range;
    logic [LOC_W-1:0] ptr_ext;

    always_comb begin
        w         = ctl_word_t'(wdata);
        upload_wr = wr_en && (w.code == CODE_UPLOAD);
        in_range  = (({2'b00, w.loc[LOC_W-1:0]} >> ADDR_W) == 16'd0);
        mem_we    = upload_wr && in_range;
        mem_wdata = w.data;
        host_addr = mem_we ? w.loc[ADDR_W-1:0] : s_q.ptr;
        ptr_ext   = '0;
        ptr_ext[ADDR_W-1:0] = s_q.ptr;

        s_d = s_q;
        if (wr_en) begin
            s_d.code = w.code;
            if (w.code == CODE_UPLOAD) begin
                if (in_range) s_d.ptr = w.loc[ADDR_W-1:0];
            end else begin
                s_d.size = w.loc;
            end
            if (w.code[3:0] == 4'hF) s_d.hold = 1'b1;
            else if (w.code[4])      s_d.hold = 1'b0;
        end else if (rd_en) begin
            if (s_q.code == CODE_UPLOAD) begin
                s_d.rword = {s_q.code, mem_rdata, 2'b00, ptr_ext};
                s_d.ptr   = s_q.ptr + 1'b1;
            end else begin
                s_d.rword = {s_q.code, 8'h00, s_q.size};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.code  <= 8'h00;
            s_q.ptr   <= '0;
            s_q.size  <= 16'h0000;
            s_q.rword <= 32'h0;
            s_q.hold  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata    = s_q.rword;
    assign core_rst = s_q.hold;

    // R6
    hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[27:24] == 4'hF) |=> core_rst);

    // R6
    hold_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[28] && wdata[27:24] != 4'hF) |=> !core_rst);

    // R3
    ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && s_q.code == CODE_UPLOAD)
        |=> s_q.ptr == ADDR_W'($past(s_q.ptr) + 1'b1));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && s_q.code != CODE_UPLOAD) |=> $stable(s_q.ptr));

    // R7
    rd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(rdata));
endmodule

// File: rtl/pld_port_mux.sv
module pld_port_mux #(
    parameter int ADDR_W = 10
) (
    input  logic              host_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        fetch_data
);
    always_comb begin
        mem_addr   = host_sel ? host_addr : fetch_addr;
        fetch_data = host_sel ? 8'h00 : mem_rdata;
    end
endmodule

// File: rtl/prog_load_port.sv
module prog_load_port
    import pld_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              mcu_rst,
    input  logic [ADDR_W-1:0] mcu_addr,
    output logic [7:0]        mcu_data
);
    logic              mem_we;
    logic [ADDR_W-1:0] host_addr;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;
    logic              host_sel;

    pld_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr),
        .rd_en     (host_rd),
        .wdata     (host_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .host_addr (host_addr),
        .mem_wdata (mem_wdata),
        .rdata     (host_rdata),
        .core_rst  (mcu_rst)
    );

    assign host_sel = mcu_rst || mem_we;

    pld_port_mux #(.ADDR_W(ADDR_W)) mux_i (
        .host_sel   (host_sel),
        .host_addr  (host_addr),
        .fetch_addr (mcu_addr),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .fetch_data (mcu_data)
    );

    pld_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // R2
    upload_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[31:24] == CODE_UPLOAD && $past(host_rd) && !$past(host_wr))
        |-> mcu_rst);

    // R8
    held_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mcu_rst) |-> mcu_data == 8'h00);
endmodule

// File: tb/prog_load_port_tb_top.sv
`timescale 1ns/1ps
module prog_load_port_tb_top;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [31:0]       host_wdata = 32'h0;
    logic [ADDR_W-1:0] mcu_addr = '0;
    logic [31:0]       host_rdata;
    logic              mcu_rst;
    logic [7:0]        mcu_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    prog_load_port #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mcu_rst(mcu_rst),
        .mcu_addr(mcu_addr), .mcu_data(mcu_data)
    );

    // op: 0 write, 1 read, 2 write and read together
    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        rst;
    } vec_t;

    localparam vec_t VEC [25] = '{
        '{2'd0, 4'd2, 32'h0F5A0003, 32'h00000000, 1'b1}, // R2
        '{2'd0, 4'd2, 32'h0FA50004, 32'h00000000, 1'b1},
        '{2'd0, 4'd2, 32'h0F3C0005, 32'h00000000, 1'b1},
        '{2'd0, 4'd2, 32'h0F110007, 32'h00000000, 1'b1},
        '{2'd0, 4'd4, 32'h0F77C006, 32'h00000000, 1'b1}, // R4 bits 15:14 set
        '{2'd0, 4'd2, 32'h0F5A0003, 32'h00000000, 1'b1},
        '{2'd1, 4'd3, 32'h0,        32'h0F5A0003, 1'b1}, // R3
        '{2'd1, 4'd3, 32'h0,        32'h0FA50004, 1'b1},
        '{2'd1, 4'd3, 32'h0,        32'h0F3C0005, 1'b1},
        '{2'd1, 4'd4, 32'h0,        32'h0F770006, 1'b1},
        '{2'd0, 4'd9, 32'h0F990407, 32'h0F770006, 1'b1}, // R9 dropped
        '{2'd1, 4'd9, 32'h0,        32'h0F110007, 1'b1},
        '{2'd2, 4'd7, 32'h0F220008, 32'h0F110007, 1'b1}, // R7
        '{2'd1, 4'd7, 32'h0,        32'h0F220008, 1'b1},
        '{2'd0, 4'd6, 32'h03000009, 32'h0F220008, 1'b1}, // R6 loaded code
        '{2'd1, 4'd5, 32'h0,        32'h03000009, 1'b1}, // R5
        '{2'd1, 4'd5, 32'h0,        32'h03000009, 1'b1},
        '{2'd0, 4'd6, 32'h13000009, 32'h03000009, 1'b0}, // R6 run code
        '{2'd1, 4'd5, 32'h0,        32'h13000009, 1'b0},
        '{2'd0, 4'd6, 32'h1FEE0003, 32'h13000009, 1'b1},
        '{2'd1, 4'd5, 32'h0,        32'h1F000003, 1'b1},
        '{2'd0, 4'd6, 32'h13000009, 32'h1F000003, 1'b0},
        '{2'd0, 4'd2, 32'h0F660002, 32'h1F000003, 1'b1},
        '{2'd1, 4'd3, 32'h0,        32'h0F660002, 1'b1},
        '{2'd1, 4'd5, 32'h0,        32'h0F5A0003, 1'b1}
    };

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic r, input logic [31:0] d);
        @(negedge clk);
        host_wr = w; host_rd = r; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all): actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1 rdata", host_rdata, 32'h0);
        check32("R1 mcu_rst", {31'b0, mcu_rst}, 32'h1);
        check32("R1 mcu_data", {24'b0, mcu_data}, 32'h0);

        foreach (VEC[i]) begin
            op(VEC[i].op != 2'd1, VEC[i].op != 2'd0, VEC[i].wd);
            check32($sformatf("R%0d vec %0d rdata", VEC[i].req, i), host_rdata, VEC[i].exp);
            check32($sformatf("R%0d vec %0d mcu_rst", VEC[i].req, i), {31'b0, mcu_rst}, {31'b0, VEC[i].rst});
        end

        // R8 fetch while running
        op(1'b1, 1'b0, 32'h13000009);
        mcu_addr = 10'd4; #1;
        check32("R8 fetch 4", {24'b0, mcu_data}, 32'hA5);
        mcu_addr = 10'd7; #1;
        check32("R8 fetch 7", {24'b0, mcu_data}, 32'h11);
        mcu_addr = 10'd2; #1;
        check32("R8 fetch 2", {24'b0, mcu_data}, 32'h66);

        // R6 loaded code leaves a running core released
        op(1'b1, 1'b0, 32'h03000009);
        check32("R6 hold after 0x03", {31'b0, mcu_rst}, 32'h0);

        // R8 held core sees zero fetch data
        op(1'b1, 1'b0, 32'h0F010000);
        mcu_addr = 10'd4; #1;
        check32("R8 held fetch", {24'b0, mcu_data}, 32'h00);

        // R4 pointer wrap at the last location
        op(1'b1, 1'b0, 32'h0F4203FF);
        op(1'b0, 1'b1, 32'h0);
        check32("R4 last loc", host_rdata, 32'h0F4203FF);
        op(1'b0, 1'b1, 32'h0);
        check32("R4 wrap to 0", host_rdata, 32'h0F010000);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check32("R1 rdata after reset", host_rdata, 32'h0);
        check32("R1 mcu_rst after reset", {31'b0, mcu_rst}, 32'h1);
        rst_n = 1'b1;

        finish_run();
    end
endmodule